// File: doc/BRIEF.md
# I2C Byte Interrupt and Clock-Stretch Controller

This block works next to an I2C byte shifter. It counts the falling edges of SCL within each transferred byte. For every byte it decides on which falling edge to raise a one-cycle byte-complete interrupt, and whether to hold SCL low from that point on. Holding SCL low stretches the clock until software acts. The decision depends on several inputs:

- the transfer phase (address, data receive or data transmit);
- whether the device is master or slave;
- a late/early timing select;
- for a slave in the address phase, the address-match, extension-code and restart flags.

Software ends a stretch with one of four cancel requests. A release bit or a shift-register write works in either role. A START request or a STOP request works only for a master. When the stretch began on the 8th edge of a received data byte, the release waits until the ACK decision for the 9th clock has been committed. The block also supplies the ACK level to drive. It forces ACK when a slave's address matches.

Top module: `i2c_stall_ctrl`

## Requirements
- R1: In a data phase (`phase` 1 = receive, 2 = transmit), the interrupt and the SCL hold begin on the 8th counted falling edge when `late_sel`=0 and on the 9th when `late_sel`=1, and there is no other interrupt in that byte.
- R2: In the address phase (`phase` 0), a master raises the interrupt and the hold on the 9th falling edge, whatever `late_sel` holds.
- R3: A slave in the address phase with `addr_match`=1 raises the interrupt and the hold on the 9th edge. `ack_level` is 1 in that state even when `ack_enable`=0. Outside that state, `ack_level` equals `ack_enable`.
- R4: A slave in the address phase with `ext_code`=1 raises the interrupt and the hold on the 8th edge.
- R5: A slave whose address does not match, with `restarted`=1, raises the interrupt on the 9th edge but does not hold SCL.
- R6: A slave whose address does not match, with no extension code and no restart, raises neither the interrupt nor the hold for that byte.
- R7: Once asserted, `scl_hold` stays high until a cancel request arrives. It drops on the clock edge that samples an accepted cancel: `rel_req` or `shreg_wr` in either role, or `start_req` / `stop_req` from a master.
- R8: A hold that began on the 8th edge in the receive phase is released only once `ack_commit` has been seen. A cancel that arrives earlier is remembered and takes effect on the edge that samples `ack_commit`.
- R9: `irq` is high for exactly one clock cycle per interrupt. It rises on the clock edge after the synchronised falling edge is detected.
- R10: In the slave role, `start_req` and `stop_req` do not release a hold.
- R11: `bus_start` and `bus_stop` clear the edge count. A falling edge is counted only after a rising edge has been seen since then, so the SCL fall that follows a START is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level (synchronised inside) |
| bus_start | input | 1 | Pulse: START or repeated START seen on the bus |
| bus_stop | input | 1 | Pulse: STOP seen on the bus |
| phase | input | 2 | 0 address, 1 data receive, 2 data transmit |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| addr_match | input | 1 | Received address equals own slave address |
| ext_code | input | 1 | Received address is an extension code |
| restarted | input | 1 | Current address followed a repeated START |
| late_sel | input | 1 | Data timing select: 0 = 8th edge, 1 = 9th edge |
| ack_enable | input | 1 | Software ACK enable |
| ack_commit | input | 1 | Pulse: ACK decision for the 9th clock captured |
| rel_req | input | 1 | Pulse: software wait-release bit set |
| shreg_wr | input | 1 | Pulse: shift register written |
| start_req | input | 1 | Pulse: software START request |
| stop_req | input | 1 | Pulse: software STOP request |
| irq | output | 1 | One-cycle byte-complete interrupt |
| scl_hold | output | 1 | 1 = drive SCL low (clock stretch) |
| ack_level | output | 1 | ACK value to drive on the 9th clock |

## Verification
The bench goes after the places where a byte's interrupt edge moves, and checks each one against the edge index it records.

- Switching `late_sel` between 8 and 9 in data phases. A design that ignored the select would fire one edge off.
- The address phase with the select set early. A design that let the select reach the address phase would fire on the 8th edge.
- An extension code. A design that treated it like a match would fire on the 9th edge.
- A restart mismatch. A design that held SCL here would stall the bus.
- A plain mismatch. A design that raised anything here would wake the slave for traffic meant for another device.

Release paths get their own checks:

- A slave `start_req` that wrongly frees the line.
- An early-point receive release that wrongly runs ahead of `ack_commit`.
- A counter not cleared by STOP, which would fire the interrupt partway through the next byte.

// File: rtl/i2c_stall_pkg.sv
`timescale 1ns/1ps
package i2c_stall_pkg;
   typedef enum logic [1:0] {
      PH_ADDR = 2'd0,
      PH_RX   = 2'd1,
      PH_TX   = 2'd2
   } xfer_phase_e;
endpackage

// File: rtl/scl_fall_counter.sv
`timescale 1ns/1ps
module scl_fall_counter #(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_BITS   = 8,
   parameter int CNT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             bus_start,
   input  logic             bus_stop,
   output logic             fall_evt,
   output logic [CNT_W-1:0] cnt_new
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   armed_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   scl_s;
   logic                   fall_raw;
   logic                   rise_raw;
   logic                   bus_clr;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("scl_fall_counter: SYNC_STAGES must be at least 2");
      end
      if (CNT_W < $clog2(BYTE_BITS + 2)) begin : g_bad_cnt
         $error("scl_fall_counter: CNT_W too narrow for BYTE_BITS");
      end
      for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= scl_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   assign scl_s    = sync_q[SYNC_STAGES-1];
   assign fall_raw = prev_q & ~scl_s;
   assign rise_raw = ~prev_q & scl_s;
   assign bus_clr  = bus_start | bus_stop;
   assign fall_evt = fall_raw & armed_q & ~bus_clr;
   assign cnt_new  = (cnt_q == CNT_LAST) ? CNT_W'(1) : cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         prev_q <= scl_s;
         if (bus_clr) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            if (rise_raw)      armed_q <= 1'b1;
            else if (fall_raw) armed_q <= 1'b0;
            if (fall_evt)      cnt_q   <= cnt_new;
         end
      end
   end

   assert_cnt_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);
   assert_clear_on_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start || bus_stop) |=> (cnt_q == '0));
endmodule

// File: rtl/stall_point_decider.sv
`timescale 1ns/1ps
module stall_point_decider
   import i2c_stall_pkg::*;
#(
   parameter int BYTE_BITS = 8,
   parameter int CNT_W     = 4
) (
   input  logic             fall_evt,
   input  logic [CNT_W-1:0] cnt_new,
   input  logic [1:0]       phase,
   input  logic             is_master,
   input  logic             addr_match,
   input  logic             ext_code,
   input  logic             restarted,
   input  logic             late_sel,
   output logic             raise_irq,
   output logic             raise_wait,
   output logic             need_ack
);
   localparam logic [CNT_W-1:0] PT_EARLY = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] PT_LATE  = CNT_W'(BYTE_BITS + 1);

   logic [CNT_W-1:0] data_pt;
   logic             at_early;
   logic             at_late;

   assign data_pt  = late_sel ? PT_LATE : PT_EARLY;
   assign at_early = fall_evt && (cnt_new == PT_EARLY);
   assign at_late  = fall_evt && (cnt_new == PT_LATE);

   always_comb begin
      raise_irq  = 1'b0;
      raise_wait = 1'b0;
      need_ack   = 1'b0;
      unique case (xfer_phase_e'(phase))
         PH_ADDR: begin
            if (is_master) begin
               raise_irq  = at_late;
               raise_wait = at_late;
            end else if (ext_code) begin
               raise_irq  = at_early;
               raise_wait = at_early;
            end else if (addr_match) begin
               raise_irq  = at_late;
               raise_wait = at_late;
            end else if (restarted) begin
               raise_irq  = at_late;
            end
         end
         PH_RX, PH_TX: begin
            raise_irq  = fall_evt && (cnt_new == data_pt);
            raise_wait = fall_evt && (cnt_new == data_pt);
            need_ack   = (xfer_phase_e'(phase) == PH_RX) && !late_sel;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/scl_wait_holder.sv
`timescale 1ns/1ps
module scl_wait_holder (
   input  logic clk,
   input  logic rst_n,
   input  logic raise_wait,
   input  logic need_ack_in,
   input  logic is_master,
   input  logic ack_commit,
   input  logic rel_req,
   input  logic shreg_wr,
   input  logic start_req,
   input  logic stop_req,
   output logic scl_hold
);
   logic hold_q;
   logic need_q;
   logic got_q;
   logic pend_q;
   logic cancel_any;
   logic ack_ok;
   logic release_now;

   assign cancel_any  = rel_req | shreg_wr | (is_master & (start_req | stop_req));
   assign ack_ok      = ~need_q | got_q | ack_commit;
   assign release_now = hold_q & (cancel_any | pend_q) & ack_ok;
   assign scl_hold    = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         need_q <= 1'b0;
         got_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (raise_wait) begin
         hold_q <= 1'b1;
         need_q <= need_ack_in;
         got_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (hold_q) begin
         if (ack_commit) got_q  <= 1'b1;
         if (cancel_any) pend_q <= 1'b1;
         if (release_now) begin
            hold_q <= 1'b0;
            pend_q <= 1'b0;
         end
      end
   end

   assert_hold_until_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !pend_q && !rel_req && !shreg_wr && !start_req && !stop_req) |=> hold_q);
   assert_ack_before_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && need_q && !got_q && !ack_commit) |=> hold_q);
   assert_slave_bus_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !is_master && !pend_q && !rel_req && !shreg_wr) |=> hold_q);
endmodule

// File: rtl/i2c_stall_ctrl.sv
`timescale 1ns/1ps
module i2c_stall_ctrl
   import i2c_stall_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_BITS   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic [1:0] phase,
   input  logic       is_master,
   input  logic       addr_match,
   input  logic       ext_code,
   input  logic       restarted,
   input  logic       late_sel,
   input  logic       ack_enable,
   input  logic       ack_commit,
   input  logic       rel_req,
   input  logic       shreg_wr,
   input  logic       start_req,
   input  logic       stop_req,
   output logic       irq,
   output logic       scl_hold,
   output logic       ack_level
);
   localparam int CNT_W = $clog2(BYTE_BITS + 2);

   logic             fall_evt;
   logic [CNT_W-1:0] cnt_new;
   logic             raise_irq;
   logic             raise_wait;
   logic             need_ack;
   logic             irq_q;
   logic             force_ack;

   generate
      if (BYTE_BITS < 1) begin : g_bad_bits
         $error("i2c_stall_ctrl: BYTE_BITS must be positive");
      end
   endgenerate

   scl_fall_counter #(
      .SYNC_STAGES (SYNC_STAGES),
      .BYTE_BITS   (BYTE_BITS),
      .CNT_W       (CNT_W)
   ) i_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .bus_start (bus_start),
      .bus_stop  (bus_stop),
      .fall_evt  (fall_evt),
      .cnt_new   (cnt_new)
   );

   stall_point_decider #(
      .BYTE_BITS (BYTE_BITS),
      .CNT_W     (CNT_W)
   ) i_decider (
      .fall_evt   (fall_evt),
      .cnt_new    (cnt_new),
      .phase      (phase),
      .is_master  (is_master),
      .addr_match (addr_match),
      .ext_code   (ext_code),
      .restarted  (restarted),
      .late_sel   (late_sel),
      .raise_irq  (raise_irq),
      .raise_wait (raise_wait),
      .need_ack   (need_ack)
   );

   scl_wait_holder i_holder (
      .clk         (clk),
      .rst_n       (rst_n),
      .raise_wait  (raise_wait),
      .need_ack_in (need_ack),
      .is_master   (is_master),
      .ack_commit  (ack_commit),
      .rel_req     (rel_req),
      .shreg_wr    (shreg_wr),
      .start_req   (start_req),
      .stop_req    (stop_req),
      .scl_hold    (scl_hold)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= raise_irq;
   end

   assign irq       = irq_q;
   assign force_ack = !is_master && (xfer_phase_e'(phase) == PH_ADDR) && addr_match;
   assign ack_level = force_ack | ack_enable;

   assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   assert_irq_follows_point_R9: assert property (@(posedge clk) disable iff (!rst_n)
      raise_irq |=> irq);
   assert_restart_miss_nowait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_irq && !is_master && phase == 2'd0 && !addr_match && !ext_code) |-> !raise_wait);
   assert_silent_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && !is_master && phase == 2'd0 && !addr_match && !ext_code && !restarted)
      |-> (!raise_irq && !raise_wait));
   assert_wait_implies_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      raise_wait |-> raise_irq);
endmodule

// File: tb/test_i2c_stall_ctrl.sv
`timescale 1ns/1ps
module test_i2c_stall_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1;
   logic       bus_start = 1'b0, bus_stop = 1'b0;
   logic [1:0] phase = 2'd0;
   logic       is_master = 1'b0, addr_match = 1'b0, ext_code = 1'b0, restarted = 1'b0;
   logic       late_sel = 1'b0, ack_enable = 1'b0, ack_commit = 1'b0;
   logic       rel_req = 1'b0, shreg_wr = 1'b0, start_req = 1'b0, stop_req = 1'b0;
   logic       irq, scl_hold, ack_level;

   int n_checks = 0, n_fail = 0;
   int irq_cnt = 0, irq_at = 0, cur_bit = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_stall_ctrl i_i2c_stall_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .bus_start(bus_start), .bus_stop(bus_stop),
      .phase(phase), .is_master(is_master), .addr_match(addr_match), .ext_code(ext_code),
      .restarted(restarted), .late_sel(late_sel), .ack_enable(ack_enable),
      .ack_commit(ack_commit), .rel_req(rel_req), .shreg_wr(shreg_wr),
      .start_req(start_req), .stop_req(stop_req), .irq(irq), .scl_hold(scl_hold),
      .ack_level(ack_level)
   );

   always @(posedge clk) if (irq) begin
      irq_cnt <= irq_cnt + 1;
      irq_at  <= cur_bit;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: rel_req = 1'b1;
         1: shreg_wr = 1'b1;
         2: start_req = 1'b1;
         3: stop_req = 1'b1;
         4: ack_commit = 1'b1;
         5: bus_start = 1'b1;
         default: bus_stop = 1'b1;
      endcase
      @(negedge clk);
      {rel_req, shreg_wr, start_req, stop_req, ack_commit, bus_start, bus_stop} = '0;
   endtask

   task automatic do_start();
      scl_in = 1'b1; cyc(4);
      pulse(5);
      cyc(2); scl_in = 1'b0; cyc(6);
   endtask

   task automatic do_stop();
      scl_in = 1'b1; cyc(4);
      pulse(6);
      cyc(4);
   endtask

   task automatic clock_bit(input int b);
      scl_in = 1'b1; cyc(4);
      scl_in = 1'b0; cur_bit = b; cyc(6);
   endtask

   task automatic setup(input int ph, input bit m, input bit am, input bit ec,
                        input bit rs, input bit ls);
      phase = 2'(ph); is_master = m; addr_match = am; ext_code = ec;
      restarted = rs; late_sel = ls;
   endtask

   // One byte: exp_at = edge of expected interrupt (0 = none), rel = cancel kind
   task automatic byte_run(input int exp_at, input bit exp_wait, input int rel, input string tag);
      int base;
      do_start();
      base = irq_cnt;
      for (int b = 1; b <= 9; b++) begin
         clock_bit(b);
         if (b == exp_at) begin
            chk(irq_cnt == base + 1, {tag, " irq count at point"}, irq_cnt - base, 1);
            chk(irq_at == b, {tag, " irq edge"}, irq_at, b);
            chk(scl_hold == exp_wait, {tag, " hold at point"}, scl_hold, exp_wait);
            if (exp_wait) begin
               pulse(rel); cyc(2);
               chk(scl_hold == 1'b0, {tag, " hold released"}, scl_hold, 0);
            end
         end
      end
      chk(irq_cnt == base + (exp_at != 0 ? 1 : 0), {tag, " irq total in byte"},
          irq_cnt - base, exp_at != 0 ? 1 : 0);
      chk(scl_hold == 1'b0, {tag, " no hold after byte"}, scl_hold, 0);
      do_stop();
   endtask

   task automatic t_reset();
      chk(irq == 1'b0, "R9 reset irq", irq, 0);
      chk(scl_hold == 1'b0, "R7 reset hold", scl_hold, 0);
   endtask

   task automatic t_data_points();
      setup(2, 1, 0, 0, 0, 0); byte_run(8, 1, 0, "R1 tx early");
      setup(1, 0, 0, 0, 0, 1); byte_run(9, 1, 1, "R1 rx late");
      setup(2, 0, 0, 0, 0, 1); byte_run(9, 1, 1, "R1 tx late slave");
   endtask

   task automatic t_address();
      setup(0, 1, 0, 0, 0, 0); byte_run(9, 1, 3, "R2 master addr");
      setup(0, 0, 1, 0, 0, 0); ack_enable = 1'b0; cyc(1);
      chk(ack_level == 1'b1, "R3 forced ack", ack_level, 1);
      byte_run(9, 1, 0, "R3 slave match");
      setup(1, 0, 0, 0, 0, 1); cyc(1);
      chk(ack_level == 1'b0, "R3 ack follows enable", ack_level, 0);
      setup(0, 0, 0, 1, 0, 0); byte_run(8, 1, 1, "R4 ext code");
      setup(0, 0, 0, 0, 1, 1); byte_run(9, 0, 0, "R5 restart miss");
      setup(0, 0, 0, 0, 0, 1); byte_run(0, 0, 0, "R6 silent miss");
   endtask

   task automatic t_slave_bus_req();
      int base;
      setup(2, 0, 0, 0, 0, 0);
      do_start(); base = irq_cnt;
      for (int b = 1; b <= 8; b++) clock_bit(b);
      chk(scl_hold == 1'b1, "R10 slave hold", scl_hold, 1);
      pulse(2); cyc(2);
      chk(scl_hold == 1'b1, "R10 start req ignored", scl_hold, 1);
      pulse(3); cyc(2);
      chk(scl_hold == 1'b1, "R10 stop req ignored", scl_hold, 1);
      cyc(10);
      chk(scl_hold == 1'b1, "R7 hold persists", scl_hold, 1);
      pulse(0); cyc(2);
      chk(scl_hold == 1'b0, "R7 release bit", scl_hold, 0);
      clock_bit(9);
      chk(irq_cnt == base + 1, "R9 single irq", irq_cnt - base, 1);
      do_stop();
      setup(1, 1, 0, 0, 0, 1); byte_run(9, 1, 2, "R7 master start req");
   endtask

   task automatic t_ack_gate();
      setup(1, 1, 0, 0, 0, 0);
      do_start();
      for (int b = 1; b <= 8; b++) clock_bit(b);
      chk(scl_hold == 1'b1, "R8 hold at 8", scl_hold, 1);
      pulse(0); cyc(4);
      chk(scl_hold == 1'b1, "R8 held without ack", scl_hold, 1);
      pulse(4); cyc(2);
      chk(scl_hold == 1'b0, "R8 released after ack", scl_hold, 0);
      clock_bit(9);
      do_stop();
   endtask

   task automatic t_counter_clear();
      int base;
      setup(2, 1, 0, 0, 0, 0);
      do_start(); base = irq_cnt;
      for (int b = 1; b <= 3; b++) clock_bit(b);
      chk(irq_cnt == base, "R11 no early irq", irq_cnt - base, 0);
      do_stop();
      byte_run(8, 1, 0, "R11 count cleared");
   endtask

   initial begin
      cyc(5); rst_n = 1'b1; cyc(3);
      t_reset();
      t_data_points();
      t_address();
      t_slave_bus_req();
      t_ack_gate();
      t_counter_clear();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule